// File: doc/BRIEF.md
# Packet Transmit Framer

The framer turns a set of configuration registers and a byte stream into one serial bit stream for a radio modulator. After a start pulse it sends three phases in a fixed order: a preamble, a sync word, and a payload of up to five fields. It moves forward by one bit on each cycle where the bit-rate strobe is high. Between strobes the output bit holds its value.

The preamble comes in one of two forms. The first is an alternating pattern whose polarity is selectable. The second is a programmable pattern of up to 32 bits that is repeated until the preamble is complete. The preamble length is given in 4-bit or 8-bit units, and a length of zero skips the preamble. The sync word is 1 to 4 bytes long. It always begins at its top byte and works downward, and each byte goes out least significant bit first. Payload bytes are taken from a ready/valid byte source, one byte at each byte boundary. The payload ends at the first field whose length is zero, or after the fifth field. If no byte is waiting when one is needed, the packet is cut short and an underflow is flagged.

Top module: `pkt_tx_framer`

## Requirements
- R1: During and after a synchronous reset, `busy`, `done`, `underflow` and `tx_bit` are all 0.
- R2: `start` while idle raises `busy` on the next cycle. `start` while busy is ignored, and the packet in flight continues unchanged.
- R3: When `cfg_std_pre` is 1, the preamble alternates starting with 1 (1,0,1,0,...). When `cfg_std_inv` is 1 it starts with 0 instead. The preamble is `cfg_pre_len` units long, where a unit is 8 bits when `cfg_len_bytes` is 1 and 4 bits when it is 0.
- R4: When `cfg_pre_len` is 0, no preamble is sent and the first bit out is sync bit 0 of byte 3.
- R5: When `cfg_std_pre` is 0, the preamble sends `cfg_pattern` bit 0 first, up to bit `cfg_pat_last`. It then wraps back to bit 0 until the preamble length is reached.
- R6: The sync word sends `cfg_sync_last`+1 bytes. It starts at byte 3 (bits 31:24) and moves downward, and each byte is sent bit 0 first.
- R7: Field k has a 13-bit byte length at `cfg_field_len[13k+12:13k]`, with fields sent in order k=0..4. Each payload byte is sent bit 0 first. The payload stops at the first field of length 0, and when field 0 has length 0 the packet has no payload.
- R8: `fifo_ready` is high only in a cycle with `bit_tick` high in which the first bit of a payload byte is due. A byte is consumed exactly when `fifo_ready` and `fifo_valid` are both high.
- R9: If `fifo_valid` is low when `fifo_ready` is high, then on the next cycle `underflow` and `done` pulse, `busy` falls, and `tx_bit` keeps its previous value.
- R10: `tx_bit` changes only on the clock edge that follows a cycle with `bit_tick` high. Each such edge during a packet presents the next bit of the stream.
- R11: `done` is a one-cycle pulse. It is raised together with the fall of `busy`, on the edge that presents the final bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a packet (honoured only while idle) |
| bit_tick | input | 1 | Bit-rate strobe; one output bit per high cycle |
| cfg_std_pre | input | 1 | 1: alternating preamble, 0: programmable pattern |
| cfg_std_inv | input | 1 | Alternating preamble starts with 0 when set |
| cfg_len_bytes | input | 1 | Preamble length unit: 1 = bytes, 0 = nibbles |
| cfg_pre_len | input | 8 | Preamble length in units; 0 skips the preamble |
| cfg_pat_last | input | 5 | Index of the last bit of the programmable pattern |
| cfg_pattern | input | 32 | Programmable preamble pattern |
| cfg_sync_last | input | 2 | Number of sync bytes minus one |
| cfg_sync | input | 32 | Sync word, byte 3 sent first |
| cfg_field_len | input | 65 | Five 13-bit payload field lengths |
| fifo_data | input | 8 | Payload byte offered by the source |
| fifo_valid | input | 1 | Source has a byte ready |
| fifo_ready | output | 1 | Framer takes the offered byte this cycle |
| tx_bit | output | 1 | Serial output bit (registered) |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle end-of-packet pulse |
| underflow | output | 1 | One-cycle pulse when a needed byte was missing |

## Verification
Each new `tx_bit` appears one clock after the strobe cycle that requests it. `busy` rises one clock after an accepted `start`. `done` and `underflow` pulse one clock after the strobe that sends the last bit or finds the source empty. `fifo_ready` is combinational and valid in the strobe cycle itself. Inputs are driven on the falling edge. The reference model steps on the rising edge and keeps its own bit queue and byte counter. All outputs are compared with the model one nanosecond after each falling edge, so registered outputs are checked after the edge that loads them and `fifo_ready` is checked against the strobe now applied. Scenarios vary the strobe spacing, both preamble kinds and both units, sync lengths, a zero-length field that truncates the payload, an empty payload, a starved source, and `start` pulses sent while a packet is running.

// File: rtl/pkt_tx_pkg.sv
`timescale 1ns/1ps
package pkt_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_SYNC = 2'd2,
    ST_PAY  = 2'd3
  } ptx_state_t;
endpackage

// File: rtl/ptx_preamble.sv
`timescale 1ns/1ps
module ptx_preamble #(
  parameter int PRE_LEN_W = 8,
  parameter int PAT_W     = 32,
  localparam int PIDX_W   = $clog2(PAT_W),
  localparam int CNT_W    = PRE_LEN_W + 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 adv,
  input  logic                 std_mode,
  input  logic                 std_inv,
  input  logic                 len_bytes,
  input  logic [PRE_LEN_W-1:0] pre_len,
  input  logic [PIDX_W-1:0]    pat_last,
  input  logic [PAT_W-1:0]     pattern,
  output logic                 bit_o,
  output logic                 last_o
);
  logic [CNT_W-1:0]  cnt;
  logic [PIDX_W-1:0] pidx;
  logic [CNT_W-1:0]  total;

  assign total  = len_bytes ? ({3'b000, pre_len} << 3) : ({3'b000, pre_len} << 2);
  assign last_o = (cnt == total - CNT_W'(1));
  assign bit_o  = std_mode ? ((~cnt[0]) ^ std_inv) : pattern[pidx];

  always_ff @(posedge clk) begin
    if (rst || load) begin
      cnt  <= '0;
      pidx <= '0;
    end else if (adv) begin
      cnt  <= cnt + CNT_W'(1);
      pidx <= (pidx == pat_last) ? '0 : pidx + PIDX_W'(1);
    end
  end
endmodule

// File: rtl/ptx_sync.sv
`timescale 1ns/1ps
module ptx_sync #(
  parameter int SYNC_BYTES = 4,
  localparam int SB_W      = $clog2(SYNC_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    adv,
  input  logic [SB_W-1:0]         sync_last,
  input  logic [SYNC_BYTES*8-1:0] sync_word,
  output logic                    bit_o,
  output logic                    last_o
);
  localparam logic [SB_W-1:0] TOP_BYTE = SB_W'(SYNC_BYTES - 1);
  logic [SB_W-1:0] byte_idx;
  logic [2:0]      bit_idx;
  logic [SB_W-1:0] end_byte;

  assign end_byte = TOP_BYTE - sync_last;
  assign bit_o    = sync_word[{byte_idx, bit_idx}];
  assign last_o   = (bit_idx == 3'd7) && (byte_idx == end_byte);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      byte_idx <= TOP_BYTE;
      bit_idx  <= '0;
    end else if (adv) begin
      bit_idx <= bit_idx + 3'd1;
      if (bit_idx == 3'd7) byte_idx <= byte_idx - SB_W'(1);
    end
  end
endmodule

// File: rtl/ptx_fields.sv
`timescale 1ns/1ps
module ptx_fields #(
  parameter int NUM_FIELDS = 5,
  parameter int FLEN_W     = 13,
  localparam int FI_W      = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic                         adv,
  input  logic [NUM_FIELDS*FLEN_W-1:0] field_len,
  input  logic [7:0]                   in_byte,
  output logic                         need_byte,
  output logic                         empty_o,
  output logic                         bit_o,
  output logic                         last_o
);
  logic [FLEN_W-1:0] flen [NUM_FIELDS];
  logic [FI_W-1:0]   fi, fi_next;
  logic [FLEN_W-1:0] bytecnt;
  logic [2:0]        bit_idx;
  logic [7:0]        sreg;
  logic              field_end, pkt_end;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_len
    assign flen[g] = field_len[g*FLEN_W +: FLEN_W];
  end

  assign fi_next   = (fi == FI_W'(NUM_FIELDS - 1)) ? fi : fi + FI_W'(1);
  assign field_end = (bytecnt == flen[fi] - FLEN_W'(1));
  assign pkt_end   = (fi == FI_W'(NUM_FIELDS - 1)) || (flen[fi_next] == '0);
  assign need_byte = (bit_idx == 3'd0);
  assign empty_o   = (flen[0] == '0);
  assign bit_o     = need_byte ? in_byte[0] : sreg[bit_idx];
  assign last_o    = (bit_idx == 3'd7) && field_end && pkt_end;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      fi      <= '0;
      bytecnt <= '0;
      bit_idx <= '0;
      sreg    <= '0;
    end else if (adv) begin
      bit_idx <= bit_idx + 3'd1;
      if (need_byte) sreg <= in_byte;
      if (bit_idx == 3'd7) begin
        if (field_end) begin
          fi      <= fi_next;
          bytecnt <= '0;
        end else begin
          bytecnt <= bytecnt + FLEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pkt_tx_framer.sv
`timescale 1ns/1ps
module pkt_tx_framer
  import pkt_tx_pkg::*;
#(
  parameter int PRE_LEN_W  = 8,
  parameter int PAT_W      = 32,
  parameter int SYNC_BYTES = 4,
  parameter int NUM_FIELDS = 5,
  parameter int FLEN_W     = 13,
  localparam int PIDX_W    = $clog2(PAT_W),
  localparam int SB_W      = $clog2(SYNC_BYTES)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         bit_tick,
  input  logic                         cfg_std_pre,
  input  logic                         cfg_std_inv,
  input  logic                         cfg_len_bytes,
  input  logic [PRE_LEN_W-1:0]         cfg_pre_len,
  input  logic [PIDX_W-1:0]            cfg_pat_last,
  input  logic [PAT_W-1:0]             cfg_pattern,
  input  logic [SB_W-1:0]              cfg_sync_last,
  input  logic [SYNC_BYTES*8-1:0]      cfg_sync,
  input  logic [NUM_FIELDS*FLEN_W-1:0] cfg_field_len,
  input  logic [7:0]                   fifo_data,
  input  logic                         fifo_valid,
  output logic                         fifo_ready,
  output logic                         tx_bit,
  output logic                         busy,
  output logic                         done,
  output logic                         underflow
);
  ptx_state_t state;
  logic load, adv_pre, adv_sync, adv_pay;
  logic pre_bit, pre_last, sync_bit, sync_last, pay_bit, pay_last, pay_need, pay_empty;

  assign load       = (state == ST_IDLE) && start;
  assign adv_pre    = (state == ST_PRE) && bit_tick;
  assign adv_sync   = (state == ST_SYNC) && bit_tick;
  assign fifo_ready = (state == ST_PAY) && bit_tick && pay_need;
  assign adv_pay    = (state == ST_PAY) && bit_tick && (!pay_need || fifo_valid);

  ptx_preamble #(.PRE_LEN_W(PRE_LEN_W), .PAT_W(PAT_W)) u_pre (
    .clk(clk), .rst(rst), .load(load), .adv(adv_pre),
    .std_mode(cfg_std_pre), .std_inv(cfg_std_inv), .len_bytes(cfg_len_bytes),
    .pre_len(cfg_pre_len), .pat_last(cfg_pat_last), .pattern(cfg_pattern),
    .bit_o(pre_bit), .last_o(pre_last)
  );

  ptx_sync #(.SYNC_BYTES(SYNC_BYTES)) u_sync (
    .clk(clk), .rst(rst), .load(load), .adv(adv_sync),
    .sync_last(cfg_sync_last), .sync_word(cfg_sync),
    .bit_o(sync_bit), .last_o(sync_last)
  );

  ptx_fields #(.NUM_FIELDS(NUM_FIELDS), .FLEN_W(FLEN_W)) u_fields (
    .clk(clk), .rst(rst), .load(load), .adv(adv_pay),
    .field_len(cfg_field_len), .in_byte(fifo_data),
    .need_byte(pay_need), .empty_o(pay_empty),
    .bit_o(pay_bit), .last_o(pay_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tx_bit    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      underflow <= 1'b0;
    end else begin
      done      <= 1'b0;
      underflow <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          busy  <= 1'b1;
          state <= (cfg_pre_len != '0) ? ST_PRE : ST_SYNC;
        end
        ST_PRE: if (bit_tick) begin
          tx_bit <= pre_bit;
          if (pre_last) state <= ST_SYNC;
        end
        ST_SYNC: if (bit_tick) begin
          tx_bit <= sync_bit;
          if (sync_last) begin
            if (pay_empty) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              state <= ST_PAY;
            end
          end
        end
        ST_PAY: if (bit_tick) begin
          if (pay_need && !fifo_valid) begin
            underflow <= 1'b1;
            done      <= 1'b1;
            busy      <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            tx_bit <= pay_bit;
            if (pay_last) begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptx_checker.sv
`timescale 1ns/1ps
module ptx_checker (
  input logic clk,
  input logic rst,
  input logic start,
  input logic bit_tick,
  input logic fifo_valid,
  input logic fifo_ready,
  input logic tx_bit,
  input logic busy,
  input logic done,
  input logic underflow
);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  assert_ready_only_busy_R8: assert property (@(posedge clk) disable iff (rst)
    fifo_ready |-> (busy && bit_tick));
  assert_underflow_done_R9: assert property (@(posedge clk) disable iff (rst)
    underflow |-> (done && !busy));
  assert_underflow_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (fifo_ready && !fifo_valid) |=> (underflow && $stable(tx_bit)));
  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(tx_bit));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_busy_fall_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

bind pkt_tx_framer ptx_checker u_ptx_checker (
  .clk(clk), .rst(rst), .start(start), .bit_tick(bit_tick),
  .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .tx_bit(tx_bit),
  .busy(busy), .done(done), .underflow(underflow)
);

// File: tb/pkt_tx_framer_bench.sv
`timescale 1ns/1ps
module pkt_tx_framer_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1, start = 1'b0, bit_tick = 1'b0;
  logic        cfg_std_pre = 1'b1, cfg_std_inv = 1'b0, cfg_len_bytes = 1'b0;
  logic [7:0]  cfg_pre_len = 8'd0;
  logic [4:0]  cfg_pat_last = 5'd0;
  logic [31:0] cfg_pattern = 32'h0;
  logic [1:0]  cfg_sync_last = 2'd0;
  logic [31:0] cfg_sync = 32'h0;
  logic [64:0] cfg_field_len = '0;
  logic [7:0]  fifo_data = 8'h00;
  logic        fifo_valid = 1'b0;
  logic        fifo_ready, tx_bit, busy, done, underflow;

  pkt_tx_framer u_pkt_tx_framer (
    .clk(clk), .rst(rst), .start(start), .bit_tick(bit_tick),
    .cfg_std_pre(cfg_std_pre), .cfg_std_inv(cfg_std_inv), .cfg_len_bytes(cfg_len_bytes),
    .cfg_pre_len(cfg_pre_len), .cfg_pat_last(cfg_pat_last), .cfg_pattern(cfg_pattern),
    .cfg_sync_last(cfg_sync_last), .cfg_sync(cfg_sync), .cfg_field_len(cfg_field_len),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
    .tx_bit(tx_bit), .busy(busy), .done(done), .underflow(underflow)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";
  logic [7:0] bq[$];
  bit qb[$];
  bit m_busy = 0, m_tx = 0, m_done = 0, m_under = 0;
  int pay_left = 0, bitpos = 0, tick_div = 1, tick_cnt = 0;
  logic [7:0] cur = 8'h00;

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Reference model, stepped on the rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_tx = 0; m_done = 0; m_under = 0;
      qb.delete(); pay_left = 0; bitpos = 0;
    end else begin
      m_done = 0; m_under = 0;
      if (!m_busy && start) begin
        int nbits;
        nbits = int'(cfg_pre_len) * (cfg_len_bytes ? 8 : 4);
        for (int k = 0; k < nbits; k++)
          qb.push_back(cfg_std_pre ? ((k % 2 == 0) ^ cfg_std_inv) : cfg_pattern[k % (int'(cfg_pat_last) + 1)]);
        for (int b = 3; b >= 3 - int'(cfg_sync_last); b--)
          for (int j = 0; j < 8; j++) qb.push_back(cfg_sync[b*8 + j]);
        pay_left = 0;
        for (int f = 0; f < 5; f++) begin
          if (cfg_field_len[f*13 +: 13] == 0) break;
          pay_left += int'(cfg_field_len[f*13 +: 13]);
        end
        bitpos = 0;
        m_busy = 1;
      end else if (m_busy && bit_tick) begin
        if (qb.size() > 0) begin
          m_tx = qb.pop_front();
          if (qb.size() == 0 && pay_left == 0) begin m_busy = 0; m_done = 1; end
        end else if (bitpos == 0) begin
          if (bq.size() == 0) begin
            m_under = 1; m_busy = 0; m_done = 1;
          end else begin
            cur = bq.pop_front(); m_tx = cur[0]; bitpos = 1;
          end
        end else begin
          m_tx = cur[bitpos];
          if (bitpos == 7) begin
            bitpos = 0; pay_left--;
            if (pay_left == 0) begin m_busy = 0; m_done = 1; end
          end else bitpos++;
        end
      end
    end
  end

  // Strobe and source drive on the falling edge, compare 1 ns later
  always @(negedge clk) begin
    bit_tick = (tick_cnt == 0);
    tick_cnt = (tick_cnt + 1) % tick_div;
    fifo_valid = (bq.size() > 0);
    fifo_data = fifo_valid ? bq[0] : 8'h00;
    #1;
    if (!rst) begin
      chk({cur_req, "/R10 tx_bit"}, tx_bit, m_tx);
      chk("R2 busy", busy, m_busy);
      chk("R11 done", done, m_done);
      chk("R9 underflow", underflow, m_under);
      chk("R8 fifo_ready", fifo_ready,
          m_busy && bit_tick && qb.size() == 0 && bitpos == 0 && pay_left > 0);
    end
  end

  task automatic set_fields(int a, int b, int c, int d, int e);
    cfg_field_len = {13'(e), 13'(d), 13'(c), 13'(b), 13'(a)};
  endtask

  task automatic run_pkt(int restart_at);
    int n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (m_busy) begin
      @(negedge clk);
      n++;
      start = (n == restart_at);
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    chk("R1 busy after reset", busy, 1'b0);
    chk("R1 done after reset", done, 1'b0);
    chk("R1 tx_bit after reset", tx_bit, 1'b0);
    chk("R1 underflow after reset", underflow, 1'b0);

    // R3 alternating preamble in nibbles, R6 four sync bytes, R7 two fields
    cur_req = "R3"; tick_div = 1;
    cfg_std_pre = 1; cfg_std_inv = 0; cfg_len_bytes = 0; cfg_pre_len = 8'd2;
    cfg_sync_last = 2'd3; cfg_sync = 32'hA5C3_1E72;
    set_fields(3, 2, 0, 0, 0);
    for (int i = 0; i < 5; i++) bq.push_back(8'(8'h31 * (i + 1)));
    run_pkt(0);
    chk_int("R7 bytes consumed two fields", bq.size(), 0);

    // R3 inverted, byte units, slow strobe; R6 two sync bytes
    cur_req = "R3"; tick_div = 3;
    cfg_std_inv = 1; cfg_len_bytes = 1; cfg_pre_len = 8'd1;
    cfg_sync_last = 2'd1; cfg_sync = 32'h96F0_0FFF;
    set_fields(1, 0, 0, 0, 0);
    bq.push_back(8'hB4);
    run_pkt(0);
    chk_int("R7 one byte consumed", bq.size(), 0);

    // R5 programmable 5-bit pattern repeated over 12 bits; R7 all five fields
    cur_req = "R5"; tick_div = 2;
    cfg_std_pre = 0; cfg_len_bytes = 0; cfg_pre_len = 8'd3;
    cfg_pat_last = 5'd4; cfg_pattern = 32'hFFFF_FFED;
    cfg_sync_last = 2'd0; cfg_sync = 32'h5A00_0000;
    set_fields(2, 1, 1, 1, 1);
    for (int i = 0; i < 6; i++) bq.push_back(8'(8'h5C + 8'h27 * i));
    run_pkt(0);
    chk_int("R7 five fields consumed", bq.size(), 0);

    // R4 zero preamble, R7 empty payload
    cur_req = "R4"; tick_div = 1;
    cfg_pre_len = 8'd0; cfg_sync_last = 2'd2; cfg_sync = 32'h1234_5678;
    set_fields(0, 4, 4, 0, 0);
    bq.push_back(8'hEE);
    run_pkt(0);
    chk_int("R7 no payload byte taken", bq.size(), 1);
    bq.delete();

    // R7 zero-length field truncates later fields
    cur_req = "R7"; tick_div = 1;
    cfg_std_pre = 1; cfg_std_inv = 0; cfg_pre_len = 8'd1;
    set_fields(1, 0, 5, 5, 5);
    bq.push_back(8'h81); bq.push_back(8'h7E);
    run_pkt(0);
    chk_int("R7 stop at zero field", bq.size(), 1);
    bq.delete();

    // R9 starved source
    cur_req = "R9"; tick_div = 2;
    set_fields(4, 0, 0, 0, 0);
    bq.push_back(8'hC9); bq.push_back(8'h36);
    run_pkt(0);
    chk_int("R9 source drained", bq.size(), 0);

    // R2 start pulses while busy are ignored
    cur_req = "R2"; tick_div = 1;
    cfg_pre_len = 8'd2; cfg_len_bytes = 1; cfg_sync_last = 2'd3;
    set_fields(2, 0, 0, 0, 0);
    bq.push_back(8'h3D); bq.push_back(8'hA2);
    run_pkt(10);
    chk_int("R2 restart ignored bytes", bq.size(), 0);
    chk("R2 idle after packet", busy, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule